// File: doc/BRIEF.md
# Descending Word Stack Controller

This block keeps the stack state for a small processor and turns push and pop commands into accesses on a single-port, word-wide memory. It holds a byte-granular stack pointer that always addresses the most recently pushed word. A push first moves the pointer down by one word (two bytes) and then writes at the new pointer. A pop reads at the current pointer and then moves the pointer up by one word. Stack transfers are whole words only.

The memory address is a 20-bit physical byte address. It is built from a 16-bit segment input, shifted left by four bits, plus the pointer. Two configuration inputs bound the stack. The ceiling is the stack's start address; reset loads the pointer from it. The floor is the lowest address the pointer may reach. A push that would take the pointer below the floor, or a pop that would take it above the ceiling, is refused. The pointer then stays where it is and a sticky error flag is raised, which stays set until the clear input is pulsed.

Each command occupies one cycle. The memory interface is driven during the command cycle, and the memory is expected to return read data one edge later. The popped word appears on the output with a one-cycle done pulse in the second cycle after the command.

Top module: `stk_unit`

## Requirements
- R1: While reset is high, the pointer loads the ceiling input, both error flags clear, pop_done_o is low, and mem_we_o is low once reset is released with no command.
- R2: An accepted push drives mem_we_o=1, mem_wdata_o=wdata_i and mem_addr_o = (seg_i*16 + sp_o - 2) mod 2^20 in the command cycle, and sp_o is 2 lower in the next cycle.
- R3: An accepted pop drives mem_we_o=0 and mem_addr_o = (seg_i*16 + sp_o) mod 2^20 in the command cycle, and sp_o is 2 higher in the next cycle.
- R4: For each accepted pop issued in cycle n, pop_done_o is high for exactly cycle n+2, and pop_data_o then carries the word the memory returned for that pop; pop_done_o is low in every other cycle.
- R5: Pushing A, B, C and then popping three times returns C, B, A in that order.
- R6: A push with sp_o < floor_i + 2 (unsigned) is refused: mem_we_o stays 0, sp_o is unchanged, and ovf_err_o is 1 from the next cycle on.
- R7: A pop with sp_o + 2 > top_i (unsigned, 17-bit sum) is refused: sp_o is unchanged, no pop_done_o pulse follows, and unf_err_o is 1 from the next cycle on.
- R8: err_clr_i clears both error flags in the next cycle; when a refused command occurs in the same cycle as err_clr_i, that command's flag is set.
- R9: When push_i and pop_i are both high, only the push is performed; the pop is ignored and cannot raise the underflow flag.
- R10: The physical address is truncated to 20 bits, so a segment near the top of the space wraps to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_i | input | 16 | Stack segment value |
| top_i | input | 16 | Ceiling: stack start address, loaded into the pointer at reset |
| floor_i | input | 16 | Lowest address the pointer may reach |
| push_i | input | 1 | Push command |
| pop_i | input | 1 | Pop command |
| wdata_i | input | 16 | Word to push |
| err_clr_i | input | 1 | Clears both sticky error flags |
| mem_addr_o | output | 20 | Physical byte address to memory |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one edge after the read address |
| pop_data_o | output | 16 | Popped word |
| pop_done_o | output | 1 | One-cycle pulse marking pop_data_o valid |
| sp_o | output | 16 | Current stack pointer |
| ovf_err_o | output | 1 | Sticky overflow flag |
| unf_err_o | output | 1 | Sticky underflow flag |

## Verification
A three-deep push-then-pop run shows that the pointer steps in word units and that data comes back in reverse order. A fill to exactly the floor followed by one extra push separates the last legal push from the first refused one. The matching drain to the ceiling does the same for pops, and back-to-back pops show that each read gets its own done pulse. Simultaneous push and pop, a clear coinciding with a refused pop, and a segment value that overflows 20 bits cover the priority, flag and wrap rules.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_cmd_decode.sv
module stk_cmd_decode #(
  parameter int AW = 16,
  parameter int STEP = 2
) (
  input  logic [AW-1:0]    sp,
  input  logic [AW-1:0]    top,
  input  logic [AW-1:0]    floor_lim,
  input  logic             push,
  input  logic             pop,
  output stk_pkg::stk_op_e op,
  output logic             ovf_hit,
  output logic             unf_hit,
  output logic [AW-1:0]    ptr_access,
  output logic [AW-1:0]    sp_next
);
  import stk_pkg::*;

  localparam int XW = AW + 1;

  logic [XW-1:0] sp_x;
  logic [XW-1:0] floor_need;
  logic [XW-1:0] sp_up;
  logic          push_ok;
  logic          pop_ok;

  always_comb begin
    sp_x       = {1'b0, sp};
    floor_need = {1'b0, floor_lim} + XW'(STEP);
    sp_up      = sp_x + XW'(STEP);
    push_ok    = (sp_x >= floor_need);
    pop_ok     = (sp_up <= {1'b0, top});

    op      = OP_IDLE;
    ovf_hit = 1'b0;
    unf_hit = 1'b0;
    if (push) begin
      if (push_ok) op = OP_PUSH;
      else begin
        op      = OP_BAD;
        ovf_hit = 1'b1;
      end
    end else if (pop) begin
      if (pop_ok) op = OP_POP;
      else begin
        op      = OP_BAD;
        unf_hit = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_access = sp;
    sp_next    = sp;
    unique case (op)
      OP_PUSH: begin
        ptr_access = sp - AW'(STEP);
        sp_next    = sp - AW'(STEP);
      end
      OP_POP:  sp_next = sp_up[AW-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_phys_addr.sv
module stk_phys_addr #(
  parameter int AW = 16,
  parameter int SEGW = 16,
  parameter int PW = 20,
  parameter int SHIFT = 4
) (
  input  logic [SEGW-1:0] seg,
  input  logic [AW-1:0]   ptr,
  output logic [PW-1:0]   phys
);
  localparam int SW0  = SEGW + SHIFT;
  localparam int SW1  = (SW0 > AW) ? SW0 : AW;
  localparam int SUMW = ((SW1 > PW) ? SW1 : PW) + 1;

  logic [SUMW-1:0] seg_w;
  logic [SUMW-1:0] sum_w;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign seg_w = SUMW'(seg);
    end else begin : g_shift
      assign seg_w = {SUMW'(seg)} << SHIFT;
    end
  endgenerate

  assign sum_w = seg_w + SUMW'(ptr);
  assign phys  = sum_w[PW-1:0];
endmodule

// File: rtl/stk_pop_return.sv
module stk_pop_return #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_issue,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] data,
  output logic          done
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      done   <= 1'b0;
      data   <= '0;
    end else begin
      pend_q <= rd_issue;
      done   <= pend_q;
      if (pend_q) data <= mem_rdata;
    end
  end
endmodule

// File: rtl/stk_unit.sv
module stk_unit #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SEGW = 16,
  parameter int PW = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SEGW-1:0] seg_i,
  input  logic [AW-1:0]   top_i,
  input  logic [AW-1:0]   floor_i,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            err_clr_i,
  output logic [PW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   pop_data_o,
  output logic            pop_done_o,
  output logic [AW-1:0]   sp_o,
  output logic            ovf_err_o,
  output logic            unf_err_o
);
  import stk_pkg::*;

  localparam int STEP = DW / 8;

  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_nxt;
  logic [AW-1:0] ptr_acc;
  logic          ovf_q;
  logic          unf_q;
  logic          ovf_hit;
  logic          unf_hit;
  stk_op_e       op;

  stk_cmd_decode #(.AW(AW), .STEP(STEP)) u_dec (
    .sp         (sp_q),
    .top        (top_i),
    .floor_lim  (floor_i),
    .push       (push_i),
    .pop        (pop_i),
    .op         (op),
    .ovf_hit    (ovf_hit),
    .unf_hit    (unf_hit),
    .ptr_access (ptr_acc),
    .sp_next    (sp_nxt)
  );

  stk_phys_addr #(.AW(AW), .SEGW(SEGW), .PW(PW), .SHIFT(SEG_SHIFT)) u_addr (
    .seg  (seg_i),
    .ptr  (ptr_acc),
    .phys (mem_addr_o)
  );

  stk_pop_return #(.DW(DW)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .rd_issue  (op == OP_POP),
    .mem_rdata (mem_rdata_i),
    .data      (pop_data_o),
    .done      (pop_done_o)
  );

  assign mem_we_o    = (op == OP_PUSH);
  assign mem_wdata_o = wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= top_i;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      sp_q  <= sp_nxt;
      ovf_q <= ovf_hit | (ovf_q & ~err_clr_i);
      unf_q <= unf_hit | (unf_q & ~err_clr_i);
    end
  end

  assign sp_o      = sp_q;
  assign ovf_err_o = ovf_q;
  assign unf_err_o = unf_q;
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] top_i,
  input logic [AW-1:0] floor_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          err_clr_i,
  input logic          mem_we_o,
  input logic          pop_done_o,
  input logic [AW-1:0] sp_o,
  input logic          ovf_err_o,
  input logic          unf_err_o
);
  localparam int STEP = DW / 8;

  logic room_dn;
  logic room_up;
  assign room_dn = ({1'b0, sp_o} >= ({1'b0, floor_i} + (AW+1)'(STEP)));
  assign room_up = (({1'b0, sp_o} + (AW+1)'(STEP)) <= {1'b0, top_i});

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sp_o == $past(top_i)) && !ovf_err_o && !unf_err_o && !pop_done_o); // R1

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    push_i && room_dn |=> sp_o == AW'($past(sp_o) - AW'(STEP))); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    pop_i && !push_i && room_up |=> sp_o == AW'($past(sp_o) + AW'(STEP))); // R3

  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    pop_done_o |-> $past(pop_i && !push_i, 2)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_i && !room_dn |-> !mem_we_o); // R6

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    push_i && !room_dn |=> ovf_err_o && $stable(sp_o)); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop_i && !push_i && !room_up |=> unf_err_o && $stable(sp_o)); // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    err_clr_i && !push_i && !pop_i |=> !ovf_err_o && !unf_err_o); // R8

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    push_i && pop_i && !unf_err_o |=> !unf_err_o); // R9
endmodule

bind stk_unit stk_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .top_i      (top_i),
  .floor_i    (floor_i),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .err_clr_i  (err_clr_i),
  .mem_we_o   (mem_we_o),
  .pop_done_o (pop_done_o),
  .sp_o       (sp_o),
  .ovf_err_o  (ovf_err_o),
  .unf_err_o  (unf_err_o)
);

// File: tb/tb_stk_unit.sv
`timescale 1ns/1ps
module tb_stk_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] seg_i = '0, top_i = '0, floor_i = '0, wdata_i = '0;
  logic        push_i = 1'b0, pop_i = 1'b0, err_clr_i = 1'b0;
  logic [19:0] mem_addr_o;
  logic        mem_we_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic [15:0] pop_data_o;
  logic        pop_done_o;
  logic [15:0] sp_o;
  logic        ovf_err_o, unf_err_o;

  always #10 clk = ~clk;

  stk_unit dut (.*);

  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (ram.exists(int'(mem_addr_o))) mem_rdata_i <= ram[int'(mem_addr_o)];
    else mem_rdata_i <= 16'h0;
    if (mem_we_o) ram[int'(mem_addr_o)] = mem_wdata_o;
  end

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  int m_sp, m_seg, m_top, m_floor;
  bit m_ovf, m_unf, pend, exp_done;
  int pend_d, exp_data;
  int q[$];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset(input int seg, input int top, input int flr);
    seg_i = 16'(seg); top_i = 16'(top); floor_i = 16'(flr);
    push_i = 0; pop_i = 0; err_clr_i = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    m_seg = seg; m_top = top; m_floor = flr; m_sp = top;
    m_ovf = 0; m_unf = 0; pend = 0; exp_done = 0; q.delete();
    #1;
    check(sp_o == 16'(top), "R1 sp after reset", sp_o, top);
    check(!ovf_err_o && !unf_err_o, "R1 flags after reset", {ovf_err_o, unf_err_o}, 0);
    check(!pop_done_o, "R1 done after reset", pop_done_o, 0);
    check(!mem_we_o, "R1 we idle", mem_we_o, 0);
  endtask

  task automatic step(input string t, input bit p, input bit o, input int d, input bit clr);
    bit acc_push, acc_pop, ovf, unf;
    int exp_addr;
    push_i = p; pop_i = o; wdata_i = 16'(d); err_clr_i = clr;
    #1;
    acc_push = p && (m_sp >= m_floor + 2);
    ovf      = p && !acc_push;
    acc_pop  = o && !p && (m_sp + 2 <= m_top);
    unf      = o && !p && !acc_pop;
    check(mem_we_o == acc_push, {t, " write enable"}, mem_we_o, acc_push);
    if (acc_push) begin
      exp_addr = ((m_seg << 4) + m_sp - 2) & 32'hFFFFF;
      check(mem_addr_o == 20'(exp_addr), {t, " R2 push addr"}, mem_addr_o, exp_addr);
      check(mem_wdata_o == 16'(d), {t, " R2 push data"}, mem_wdata_o, d);
    end
    if (acc_pop) begin
      exp_addr = ((m_seg << 4) + m_sp) & 32'hFFFFF;
      check(mem_addr_o == 20'(exp_addr), {t, " R3 pop addr"}, mem_addr_o, exp_addr);
    end
    exp_done = pend;
    exp_data = pend_d;
    pend = acc_pop;
    if (acc_push) begin q.push_back(d); m_sp -= 2; end
    if (acc_pop) begin pend_d = q.pop_back(); m_sp += 2; end
    m_ovf = ovf || (m_ovf && !clr);
    m_unf = unf || (m_unf && !clr);
    @(negedge clk);
    push_i = 0; pop_i = 0; err_clr_i = 0;
    #1;
    check(sp_o == 16'(m_sp), {t, " sp"}, sp_o, m_sp);
    check(ovf_err_o == m_ovf, {t, " R6 ovf flag"}, ovf_err_o, m_ovf);
    check(unf_err_o == m_unf, {t, " R7 unf flag"}, unf_err_o, m_unf);
    check(pop_done_o == exp_done, {t, " R4 done"}, pop_done_o, exp_done);
    if (exp_done)
      check(pop_data_o == 16'(exp_data), {t, " R4 R5 pop data"}, pop_data_o, exp_data);
    #1;
  endtask

  initial begin
    @(negedge clk);
    do_reset(16'h1234, 16'h0100, 16'h00F0);
    step("R2", 1, 0, 16'hAAAA, 0);
    step("R2", 1, 0, 16'hBBBB, 0);
    step("R2", 1, 0, 16'hCCCC, 0);
    step("R5", 0, 1, 0, 0);
    step("R5", 0, 1, 0, 0);
    step("R5", 0, 1, 0, 0);
    step("R4", 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R2", 1, 0, 16'h1000 + i * 16'h0111, 0);
    step("R6", 1, 0, 16'hDEAD, 0);
    step("R6", 1, 0, 16'hBEEF, 0);
    for (int i = 0; i < 8; i++) step("R3", 0, 1, 0, 0);
    step("R7", 0, 1, 0, 0);
    step("R4", 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1);
    step("R8", 0, 1, 0, 1);
    step("R8", 0, 0, 0, 1);
    step("R9", 1, 1, 16'h5A5A, 0);
    step("R9", 0, 1, 0, 0);
    step("R9", 1, 1, 16'h0F0F, 0);
    step("R9", 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0);
    do_reset(16'hFFFF, 16'h0100, 16'h0000);
    step("R10", 1, 0, 16'h7777, 0);
    step("R10", 1, 0, 16'h8888, 0);
    step("R10", 0, 1, 0, 0);
    step("R10", 0, 1, 0, 0);
    step("R10", 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule